// File: doc/BRIEF.md
# DSP Program Boot Loader Sequencer

This block sits on the host side of a byte-wide port into a signal processor and pushes a complete program image into it. A single start command, together with a count of 24-bit program words, launches a fixed sequence on one active-low select line: a long reset pulse, two pulses that carry the total number of bytes to follow, and then three pulses for every program word. The program bytes come from a byte stream with valid/ready flow control. The block takes them in arrival order and places each one on the data bus for its own select pulse.

Every timing figure is a count of system clock cycles set by a parameter: the width of the reset pulse, the low time of an ordinary strobe, and the idle gap after each strobe. The defaults give about 400 cycles per byte on a 200 MHz clock, roughly 2 us per byte and 6 us per word. The busy flag covers the whole load. A one-cycle done pulse marks the end of the load.

Top module: `dsp_boot_seq`

## Requirements
- R1: After a synchronous reset, sel_n_o is 1, busy_o is 0, done_o is 0, s_ready_o is 0 and bus_o is 0x00.
- R2: A start_i pulse sampled while idle raises busy_o on the next clock. The first select pulse of the load is the reset pulse: it is low for exactly RST_CYC cycles with bus_o = 0x00. While busy_o is 0, sel_n_o stays high.
- R3: Every select pulse after the reset pulse is low for exactly LOW_CYC cycles.
- R4: The second and third select pulses carry the byte count B = 3 × word_cnt_i as a 16-bit value. The low byte B[7:0] goes out first and the high byte B[15:8] second.
- R5: After the count, exactly 3 × word_cnt_i pulses follow. Each carries the next accepted stream byte in arrival order. Per word, the stream supplies bits [23:16], then [15:8], then [7:0].
- R6: bus_o does not change while sel_n_o is low, nor in the first cycle after sel_n_o returns high.
- R7: While the stream offers no byte, sel_n_o stays high. A stall of any length, including one in the middle of a word, loses no byte and repeats no byte.
- R8: A start_i pulse while busy_o is 1 is ignored. The load in progress keeps its strobe count and its byte values.
- R9: After the last strobe and its trailing gap, done_o is 1 for exactly one cycle and busy_o falls in that same cycle. A word count of 0 produces only the reset and count strobes, then done.
- R10: s_ready_o is 1 only while busy_o is 1, and never before the two count strobes have completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a load; ignored while busy |
| word_cnt_i | input | WORD_W | Number of 24-bit program words, sampled at start |
| s_data_i | input | 8 | Program byte stream data |
| s_valid_i | input | 1 | Stream byte valid |
| s_ready_o | output | 1 | Sequencer accepts a stream byte |
| sel_n_o | output | 1 | Active-low select strobe to the DSP host port |
| bus_o | output | 8 | Byte placed on the host port |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | One-cycle pulse when the load has finished |

## Verification
The bench builds the block with WORD_W = 8, RST_CYC = 5, LOW_CYC = 3 and GAP_CYC = 2, so one byte takes about eight cycles. These values keep a full 255-word image short enough to run. They still give a count whose high byte is non-zero (765 = 0x02FD), which exercises the byte order of the count. Distinct reset and strobe widths let the bench tell the reset pulse from the data pulses. The short gap means random stalls and a directed long stall in the middle of a word land on every phase of the strobe cycle. A second start during a load is also exercised.

// File: rtl/dspb_pkg.sv
package dspb_pkg;

  // Top-level sequencer states.
  typedef enum logic [2:0] {
    S_IDLE,
    S_PICK,
    S_SETUP,
    S_LOW,
    S_HOLD,
    S_GAP
  } seq_state_t;

  // Which strobe was sent last in the current load.
  typedef enum logic [1:0] {
    P_RST,
    P_CLO,
    P_CHI,
    P_DATA
  } seq_phase_t;

  localparam int unsigned COUNT_W = 16;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned BYTES_PER_WORD = 3;

  function automatic logic [COUNT_W-1:0] bytes_for_words(input logic [COUNT_W-1:0] words);
    return COUNT_W'(words * COUNT_W'(BYTES_PER_WORD));
  endfunction

endpackage

// File: rtl/dspb_pacer.sv
// Down-counter that times strobe low periods and gaps.
module dspb_pacer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - W'(1);
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/dspb_byte_sel.sv
// Chooses the next byte for the host port from the load phase.
module dspb_byte_sel
  import dspb_pkg::*;
(
  input  seq_phase_t          phase,
  input  logic [COUNT_W-1:0]  total,
  input  logic [BYTE_W-1:0]   s_data,
  output logic [BYTE_W-1:0]   next_byte,
  output logic                want_stream
);

  always_comb begin
    unique case (phase)
      P_RST:   next_byte = total[7:0];
      P_CLO:   next_byte = total[15:8];
      default: next_byte = s_data;
    endcase
    want_stream = (phase == P_CHI) || (phase == P_DATA);
  end

endmodule

// File: rtl/dsp_boot_seq.sv
module dsp_boot_seq
  import dspb_pkg::*;
#(
  parameter int unsigned WORD_W  = 14,
  parameter int unsigned RST_CYC = 200,
  parameter int unsigned LOW_CYC = 100,
  parameter int unsigned GAP_CYC = 297
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [WORD_W-1:0] word_cnt_i,
  input  logic [7:0]        s_data_i,
  input  logic              s_valid_i,
  output logic              s_ready_o,
  output logic              sel_n_o,
  output logic [7:0]        bus_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam int unsigned MAX_A = (RST_CYC > LOW_CYC) ? RST_CYC : LOW_CYC;
  localparam int unsigned MAX_B = (MAX_A > GAP_CYC) ? MAX_A : GAP_CYC;
  localparam int unsigned TMR_W = $clog2(MAX_B + 1);

  seq_state_t          state_q;
  seq_phase_t          phase_q;
  logic [COUNT_W-1:0]  total_q;
  logic [COUNT_W-1:0]  left_q;
  logic [BYTE_W-1:0]   bus_q;
  logic                sel_n_q;
  logic                busy_q;
  logic                done_q;

  logic                tmr_load;
  logic [TMR_W-1:0]    tmr_val;
  logic                tmr_expired;
  logic [BYTE_W-1:0]   next_byte;
  logic                want_stream;
  logic                take_byte;

  // Timer: loaded entering the low period and entering the gap.
  always_comb begin
    tmr_load = (state_q == S_SETUP) || (state_q == S_HOLD);
    if (state_q == S_HOLD) begin
      tmr_val = TMR_W'(GAP_CYC - 1);
    end else if (phase_q == P_RST) begin
      tmr_val = TMR_W'(RST_CYC - 1);
    end else begin
      tmr_val = TMR_W'(LOW_CYC - 1);
    end
  end

  dspb_pacer #(.W(TMR_W)) u_pacer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  dspb_byte_sel u_sel (
    .phase       (phase_q),
    .total       (total_q),
    .s_data      (s_data_i),
    .next_byte   (next_byte),
    .want_stream (want_stream)
  );

  assign s_ready_o = (state_q == S_PICK) && want_stream && (left_q != '0);
  assign take_byte = s_ready_o && s_valid_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      phase_q <= P_RST;
      total_q <= '0;
      left_q  <= '0;
      bus_q   <= '0;
      sel_n_q <= 1'b1;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (start_i) begin
            total_q <= bytes_for_words(COUNT_W'(word_cnt_i));
            left_q  <= bytes_for_words(COUNT_W'(word_cnt_i));
            phase_q <= P_RST;
            bus_q   <= '0;
            busy_q  <= 1'b1;
            state_q <= S_SETUP;
          end
        end
        S_PICK: begin
          if (!want_stream) begin
            bus_q   <= next_byte;
            phase_q <= (phase_q == P_RST) ? P_CLO : P_CHI;
            state_q <= S_SETUP;
          end else if (left_q == '0) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end else if (take_byte) begin
            bus_q   <= next_byte;
            left_q  <= left_q - COUNT_W'(1);
            phase_q <= P_DATA;
            state_q <= S_SETUP;
          end
        end
        S_SETUP: begin
          sel_n_q <= 1'b0;
          state_q <= S_LOW;
        end
        S_LOW: begin
          if (tmr_expired) begin
            sel_n_q <= 1'b1;
            state_q <= S_HOLD;
          end
        end
        S_HOLD: begin
          state_q <= S_GAP;
        end
        S_GAP: begin
          if (tmr_expired) begin
            state_q <= S_PICK;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign sel_n_o = sel_n_q;
  assign bus_o   = bus_q;
  assign busy_o  = busy_q;
  assign done_o  = done_q;

endmodule

// File: rtl/dsp_boot_seq_chk.sv
module dsp_boot_seq_chk #(
  parameter int unsigned RST_CYC = 200,
  parameter int unsigned LOW_CYC = 100
) (
  input logic       clk,
  input logic       rst,
  input logic       sel_n_o,
  input logic [7:0] bus_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       s_ready_o,
  input logic       s_valid_i
);

  int unsigned lo_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_run <= 0;
    end else begin
      if (!sel_n_o) lo_run <= lo_run + 1;
      else          lo_run <= 0;
      if (sel_n_o && lo_run != 0) begin
        a_r3_low_width: assert (lo_run == LOW_CYC || lo_run == RST_CYC)
          else $error("strobe low width %0d", lo_run);
      end
    end
  end

  a_r6_bus_stable_low: assert property (@(posedge clk) disable iff (rst)
    (!sel_n_o && !$past(sel_n_o)) |-> $stable(bus_o));

  a_r6_bus_hold: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_n_o) |-> $stable(bus_o));

  a_r2_idle_no_strobe: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> sel_n_o);

  a_r7_stall_no_strobe: assert property (@(posedge clk) disable iff (rst)
    (s_ready_o && !s_valid_i) |=> sel_n_o);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o)));

  a_r10_ready_busy: assert property (@(posedge clk) disable iff (rst)
    s_ready_o |-> busy_o);

endmodule

bind dsp_boot_seq dsp_boot_seq_chk #(
  .RST_CYC (RST_CYC),
  .LOW_CYC (LOW_CYC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sel_n_o   (sel_n_o),
  .bus_o     (bus_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .s_ready_o (s_ready_o),
  .s_valid_i (s_valid_i)
);

// File: tb/tb_dsp_boot_seq.sv
`timescale 1ns/1ps
module tb_dsp_boot_seq;

  localparam int unsigned WORD_W  = 8;
  localparam int unsigned RST_CYC = 5;
  localparam int unsigned LOW_CYC = 3;
  localparam int unsigned GAP_CYC = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start_i = 1'b0;
  logic [WORD_W-1:0] word_cnt_i = '0;
  logic [7:0]        s_data_i = '0;
  logic              s_valid_i = 1'b0;
  logic              s_ready_o;
  logic              sel_n_o;
  logic [7:0]        bus_o;
  logic              busy_o;
  logic              done_o;

  always #2.5 clk = ~clk;

  dsp_boot_seq #(
    .WORD_W (WORD_W), .RST_CYC (RST_CYC), .LOW_CYC (LOW_CYC), .GAP_CYC (GAP_CYC)
  ) dut (
    .clk (clk), .rst (rst), .start_i (start_i), .word_cnt_i (word_cnt_i),
    .s_data_i (s_data_i), .s_valid_i (s_valid_i), .s_ready_o (s_ready_o),
    .sel_n_o (sel_n_o), .bus_o (bus_o), .busy_o (busy_o), .done_o (done_o)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // Monitor state
  logic [7:0] cap   [0:1023];
  int         width [0:1023];
  int         ncap = 0;
  int         low_w = 0;
  logic [7:0] cur_bus = '0;
  logic       prev_sel = 1'b1;
  int         bad_stab = 0;
  int         bad_ready = 0;
  int         ndone = 0;

  logic [7:0] img [0:767];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (prev_sel && !sel_n_o) begin
        cap[ncap] = bus_o;
        cur_bus   = bus_o;
        low_w     = 1;
        ncap++;
      end else if (!sel_n_o) begin
        low_w++;
        if (bus_o != cur_bus) bad_stab++;
      end else if (!prev_sel) begin
        if (bus_o != cur_bus) bad_stab++;
        width[ncap-1] = low_w;
      end
      if (done_o) ndone++;
      if (s_ready_o && ncap < 3) bad_ready++;
      prev_sel = sel_n_o;
    end
  end

  function automatic logic [7:0] exp_strobe(input int k, input int n);
    logic [15:0] b;
    b = 16'(3 * n);
    if (k == 0) return 8'h00;
    if (k == 1) return b[7:0];
    if (k == 2) return b[15:8];
    return img[k-3];
  endfunction

  task automatic do_load(input int n, input int stall_pct, input bit poke,
                         input int stall_idx);
    for (int i = 0; i < 3 * n; i++) img[i] = 8'($urandom);
    @(negedge clk);
    ncap = 0; bad_stab = 0; bad_ready = 0; ndone = 0;
    word_cnt_i = WORD_W'(n);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R2 busy after start", int'(busy_o), 1);
    fork
      begin : drv
        int  idx = 0;
        bit  stalled = 0;
        while (idx < 3 * n) begin
          @(negedge clk);
          if (idx == stall_idx && !stalled) begin
            s_valid_i = 1'b0;
            repeat (40) @(negedge clk);
            chk(ncap == 3 + stall_idx, "R7 no strobe in stall", ncap, 3 + stall_idx);
            stalled = 1;
          end
          s_valid_i = (($urandom % 100) >= stall_pct);
          s_data_i  = img[idx];
          if (s_valid_i && s_ready_o) idx++;
        end
        @(negedge clk);
        s_valid_i = 1'b0;
      end
      begin : pk
        if (poke) begin
          wait (ncap >= 5);
          @(negedge clk);
          word_cnt_i = WORD_W'(n + 7);
          start_i = 1'b1;
          @(negedge clk);
          start_i = 1'b0;
          word_cnt_i = WORD_W'(n);
        end
      end
      begin : wt
        wait (ndone != 0);
        repeat (4) @(negedge clk);
      end
    join
    chk(ncap == 3 * n + 3, "R5 R8 strobe count", ncap, 3 * n + 3);
    for (int k = 0; k < ncap && k < 3 * n + 3; k++) begin
      if (k == 0) begin
        chk(cap[k] == 8'h00, "R2 reset strobe value", cap[k], 0);
        chk(width[k] == RST_CYC, "R2 reset strobe width", width[k], RST_CYC);
      end else begin
        if (k < 3) chk(cap[k] == exp_strobe(k, n), "R4 count byte", cap[k], exp_strobe(k, n));
        else       chk(cap[k] == exp_strobe(k, n), "R5 R7 R8 program byte", cap[k], exp_strobe(k, n));
        chk(width[k] == LOW_CYC, "R3 strobe width", width[k], LOW_CYC);
      end
    end
    chk(bad_stab == 0, "R6 bus stability", bad_stab, 0);
    chk(ndone == 1, "R9 single done pulse", ndone, 1);
    chk(busy_o == 1'b0, "R9 busy low after done", int'(busy_o), 0);
    chk(bad_ready == 0, "R10 ready before count", bad_ready, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0B07));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(sel_n_o == 1'b1, "R1 sel_n", int'(sel_n_o), 1);
    chk(busy_o == 1'b0, "R1 busy", int'(busy_o), 0);
    chk(done_o == 1'b0, "R1 done", int'(done_o), 0);
    chk(s_ready_o == 1'b0, "R1 ready", int'(s_ready_o), 0);
    chk(bus_o == 8'h00, "R1 bus", bus_o, 0);

    do_load(4, 0, 0, -1);      // plain load
    do_load(100, 30, 0, -1);   // random stalls
    do_load(255, 0, 0, -1);    // largest count, high byte non-zero (R4)
    do_load(0, 0, 0, -1);      // zero words (R9)
    do_load(6, 10, 1, -1);     // start while busy (R8)
    do_load(5, 0, 0, 4);       // long stall mid-word (R7)
    do_load(20, 80, 0, -1);    // heavy stalls (R7)

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule